// File: doc/BRIEF.md
# Sticky Floating-Point Exception Flag Register

This block keeps the accumulated exception status of a floating-point datapath. Several result buses, one per arithmetic pipe, each present an enable and a vector of exception flags. In every cycle the flags of all enabled buses are ORed into the held value. Once a flag is set it stays set. No arithmetic result can clear it.

Software changes the register only through a dedicated write port, and that is the only way a flag can return to zero. A producer update can arrive in the same cycle as that write. In that case the written value is ORed with the producer flags, and the old contents are dropped. An exception raised in that cycle is therefore never lost. The read port shows the stored value directly, with no added latency.

Top module: `fp_xflag_reg`

## Requirements
- R1: A synchronous active-high reset clears every held flag to zero, and reset takes precedence over any write or producer update in the same cycle.
- R2: The read port equals the stored value at all times; a change driven on the inputs appears on the read port only after the next rising clock edge.
- R3: A producer port whose enable is 1 has its flag vector ORed into the stored value at the next rising edge.
- R4: A producer port whose enable is 0 contributes nothing, whatever its flag vector holds.
- R5: When several producer ports are enabled in one cycle, each stored flag becomes the OR of all their flags and its previous value.
- R6: Without a software write, no stored flag ever goes from 1 to 0.
- R7: A software write with no enabled producer replaces the stored value with the written value, which may clear flags.
- R8: A software write in the same cycle as enabled producers stores the written value ORed with those producers' flags; the previous stored value is discarded.
- R9: Flag bit positions are fixed: bit 0 invalid operation, bit 1 divide by zero, bit 2 overflow, bit 3 underflow, bit 4 inexact, bit 5 input flushed to zero, bit 6 output flushed to zero. Producer port i occupies bits [7*i+6 : 7*i] of the packed flag input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| prod_en | input | 4 | Per-producer update enable (guard LSB) |
| prod_flags | input | 28 | Packed producer flag vectors, 7 bits per port |
| sw_wr_en | input | 1 | Explicit software write strobe |
| sw_wr_data | input | 7 | Value for the explicit write |
| flags_rd | output | 7 | Current stored flags |

## Verification
The hardest situation to reach is a software write that clears flags in the same cycle as a producer raises new ones. An idle producer must then leave the cleared bits at zero, while an active one must restore only its own bits. The table drives writes together with enabled and disabled ports. Some of the disabled ports carry all-ones vectors, so a leak through the enable gating or through the old value shows up on the read port one edge later. Reset is also asserted while every port is active, which shows that reset wins over the merge.

// File: rtl/fsx_pkg.sv
package fsx_pkg;

    // Number of exception kinds held by the register
    localparam int XF_COUNT = 7;
    // Default number of producer result buses
    localparam int XF_PORTS = 4;

    // Bit position of each exception kind inside a flag vector
    typedef enum int {
        XF_INVALID  = 0,
        XF_DIVZERO  = 1,
        XF_OVERFLOW = 2,
        XF_UNDRFLOW = 3,
        XF_INEXACT  = 4,
        XF_INFLUSH  = 5,
        XF_OUTFLUSH = 6
    } xf_bit_e;

endpackage

// File: rtl/fsx_merge.sv
// OR-merges the flag vectors of all enabled producer ports.
module fsx_merge #(
    parameter int NPORT  = fsx_pkg::XF_PORTS,
    parameter int FLAG_W = fsx_pkg::XF_COUNT,
    localparam int BUS_W = NPORT * FLAG_W
) (
    input  logic [NPORT-1:0]  prod_en,
    input  logic [BUS_W-1:0]  prod_flags,
    output logic [FLAG_W-1:0] merged
);

    // acc[k] holds the OR of the gated vectors of ports 0..k-1
    logic [FLAG_W-1:0] acc [NPORT+1];

    assign acc[0] = '0;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        logic [FLAG_W-1:0] gated;
        assign gated      = prod_en[g] ? prod_flags[g*FLAG_W +: FLAG_W] : '0;
        assign acc[g + 1] = acc[g] | gated;
    end

    assign merged = acc[NPORT];

endmodule

// File: rtl/fsx_select.sv
// Chooses the base value for the next state: the software value on a
// write, otherwise the held flags, then ORs in this cycle's producer flags.
module fsx_select #(
    parameter int FLAG_W = fsx_pkg::XF_COUNT
) (
    input  logic [FLAG_W-1:0] cur_flags,
    input  logic [FLAG_W-1:0] merged,
    input  logic              sw_wr_en,
    input  logic [FLAG_W-1:0] sw_wr_data,
    output logic [FLAG_W-1:0] nxt_flags
);

    logic [FLAG_W-1:0] base;

    always_comb begin
        base      = sw_wr_en ? sw_wr_data : cur_flags;
        nxt_flags = base | merged;
    end

endmodule

// File: rtl/fp_xflag_reg.sv
// Sticky floating-point exception flag register with several producers.
module fp_xflag_reg #(
    parameter int NPORT  = fsx_pkg::XF_PORTS,
    parameter int FLAG_W = fsx_pkg::XF_COUNT,
    localparam int BUS_W = NPORT * FLAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORT-1:0]  prod_en,
    input  logic [BUS_W-1:0]  prod_flags,
    input  logic              sw_wr_en,
    input  logic [FLAG_W-1:0] sw_wr_data,
    output logic [FLAG_W-1:0] flags_rd
);

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } xf_state_t;

    xf_state_t         st_d;
    xf_state_t         st_q;
    logic [FLAG_W-1:0] merged;
    logic [FLAG_W-1:0] sel_flags;

    fsx_merge #(
        .NPORT  (NPORT),
        .FLAG_W (FLAG_W)
    ) u_merge (
        .prod_en    (prod_en),
        .prod_flags (prod_flags),
        .merged     (merged)
    );

    fsx_select #(
        .FLAG_W (FLAG_W)
    ) u_select (
        .cur_flags  (st_q.flags),
        .merged     (merged),
        .sw_wr_en   (sw_wr_en),
        .sw_wr_data (sw_wr_data),
        .nxt_flags  (sel_flags)
    );

    always_comb begin
        st_d       = st_q;
        st_d.flags = sel_flags;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_rd = st_q.flags;

    // R1: reset empties the register whatever else is driven
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (flags_rd == '0));

    // R6: without a software write no held bit drops
    assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !sw_wr_en |=> ((flags_rd & $past(flags_rd)) == $past(flags_rd)));

    // R4: nothing enabled and no write leaves the register unchanged
    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr_en && prod_en == '0) |=> $stable(flags_rd));

    // R7: a write with no producer loads the written value exactly
    assert_write_load_R7: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_en && prod_en == '0) |=> (flags_rd == $past(sw_wr_data)));

    // R8: the written value is always kept, merged with producer flags
    assert_write_merge_R8: assert property (@(posedge clk) disable iff (rst)
        sw_wr_en |=> ((flags_rd & $past(sw_wr_data)) == $past(sw_wr_data)));

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        // R5: every enabled port's flags are present in the merged vector
        assert_port_merged_R5: assert property (@(posedge clk) disable iff (rst)
            prod_en[p] |->
                ((merged & prod_flags[p*FLAG_W +: FLAG_W]) ==
                 prod_flags[p*FLAG_W +: FLAG_W]));

        // R3: an enabled port's flags are held after the next edge
        assert_port_lands_R3: assert property (@(posedge clk) disable iff (rst)
            prod_en[p] |=>
                ((flags_rd & $past(prod_flags[p*FLAG_W +: FLAG_W])) ==
                 $past(prod_flags[p*FLAG_W +: FLAG_W])));
    end

endmodule

// File: tb/fp_xflag_reg_tb.sv
module fp_xflag_reg_tb;

    localparam int NP = 4;
    localparam int FW = 7;

    typedef struct packed {
        logic          wr;
        logic [FW-1:0] wdat;
        logic [NP-1:0] en;
        logic [FW-1:0] f3;
        logic [FW-1:0] f2;
        logic [FW-1:0] f1;
        logic [FW-1:0] f0;
        logic [FW-1:0] exp;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'h00, 4'b0001, 7'h00, 7'h00, 7'h00, 7'h01, 7'h01, 4'd3},
        '{1'b0, 7'h00, 4'b0000, 7'h7F, 7'h7F, 7'h7F, 7'h7F, 7'h01, 4'd4},
        '{1'b0, 7'h00, 4'b0110, 7'h7F, 7'h10, 7'h02, 7'h7F, 7'h13, 4'd5},
        '{1'b0, 7'h00, 4'b1111, 7'h40, 7'h20, 7'h00, 7'h04, 7'h77, 4'd5},
        '{1'b0, 7'h00, 4'b0000, 7'h00, 7'h00, 7'h00, 7'h00, 7'h77, 4'd6},
        '{1'b1, 7'h00, 4'b0000, 7'h7F, 7'h7F, 7'h7F, 7'h7F, 7'h00, 4'd7},
        '{1'b1, 7'h08, 4'b0000, 7'h00, 7'h00, 7'h00, 7'h00, 7'h08, 4'd7},
        '{1'b1, 7'h00, 4'b1000, 7'h02, 7'h7F, 7'h7F, 7'h7F, 7'h02, 4'd8},
        '{1'b1, 7'h01, 4'b0001, 7'h00, 7'h00, 7'h00, 7'h40, 7'h41, 4'd8},
        '{1'b0, 7'h00, 4'b1010, 7'h00, 7'h7F, 7'h00, 7'h7F, 7'h41, 4'd6},
        '{1'b0, 7'h00, 4'b1111, 7'h7F, 7'h7F, 7'h7F, 7'h7F, 7'h7F, 4'd5},
        '{1'b1, 7'h7F, 4'b0000, 7'h00, 7'h00, 7'h00, 7'h00, 7'h7F, 4'd7}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic [NP-1:0]     prod_en;
    logic [NP*FW-1:0]  prod_flags;
    logic              sw_wr_en;
    logic [FW-1:0]     sw_wr_data;
    logic [FW-1:0]     flags_rd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fp_xflag_reg u_dut (
        .clk        (clk),
        .rst        (rst),
        .prod_en    (prod_en),
        .prod_flags (prod_flags),
        .sw_wr_en   (sw_wr_en),
        .sw_wr_data (sw_wr_data),
        .flags_rd   (flags_rd)
    );

    task automatic check(input string req, input logic [FW-1:0] exp);
        n_chk++;
        if (flags_rd !== exp) begin
            n_fail++;
            $display("FAIL %s: flags_rd=%h expected=%h", req, flags_rd, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [FW-1:0] wd,
                         input logic [NP-1:0] en, input logic [NP*FW-1:0] f);
        sw_wr_en   = wr;
        sw_wr_data = wd;
        prod_en    = en;
        prod_flags = f;
    endtask

    // drive at falling edge, register at rising edge, sample next falling edge
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, '0, '0, '0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", 7'h00);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].wr, VECS[i].wdat, VECS[i].en,
                  {VECS[i].f3, VECS[i].f2, VECS[i].f1, VECS[i].f0});
            step();
            check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp);
        end

        // R2: new inputs do not show on the read port before the edge
        drive(1'b1, 7'h00, 4'b1111, '1);
        #2;
        check("R2", 7'h7F);
        drive(1'b1, 7'h00, 4'b0000, '0);
        step();
        check("R7 clear all", 7'h00);
        drive(1'b0, 7'h00, 4'b0000, '0);

        // R9: divide-by-zero on port 2 lands at bit 1 only
        drive(1'b0, 7'h00, 4'b0100,
              {7'h00, 7'(1 << fsx_pkg::XF_DIVZERO), 7'h00, 7'h00});
        step();
        check("R9 divzero bit", 7'h02);
        // R9: output-flushed on port 3 lands at bit 6
        drive(1'b0, 7'h00, 4'b1000,
              {7'(1 << fsx_pkg::XF_OUTFLUSH), 7'h00, 7'h00, 7'h00});
        step();
        check("R9 outflush bit", 7'h42);

        // R1: reset wins over full producer activity and a write
        drive(1'b1, 7'h7F, 4'b1111, '1);
        rst = 1'b1;
        step();
        check("R1 reset priority", 7'h00);
        rst = 1'b0;
        drive(1'b0, 7'h00, 4'b0000, '0);
        step();
        check("R1 after reset", 7'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule